// File: doc/BRIEF.md
# Synchronous Clock Pulse Gating Controller

This block decides, for every strobe of a free-running master pulse stream, whether that pulse is forwarded to the logic it feeds. The decision comes from an operating mode picked by five front-panel mode keys. A flag from the controlled machine can also re-open delivery by itself. The block works on a fast system clock. A master pulse is a one-cycle strobe, and `pass_en` marks the strobe cycles whose pulse goes through. Because the gate only ever acts on whole strobe cycles, a mode change at any moment can neither cut a pulse short nor add one.

There are five modes, held in the state register: NORMAL, REPEAT, STOP, DIGIT and NUMBER. Reset enters STOP. Each mode key is edge-detected. On a key edge the machine jumps to that key's state. When keys arrive together, the highest-priority key wins. An "armed" bit holds the permission for the next pulse(s):
- a rate tick sets it in REPEAT;
- a step key sets it when already in STOP;
- entering DIGIT or NUMBER sets it.

A passed pulse clears it in REPEAT and STOP. In DIGIT or NUMBER it is cleared by a passed pulse that coincides with the registered boundary flag.

A separate host-run path opens delivery in every mode except NORMAL when the host key flag rises. It closes either on the operation-started flag or, in the counted variant, after a fixed number of passed pulses. All host-side flags are active-low at the pins and are inverted and registered inside the block.

Top module: `pulse_gate_ctrl`

## Requirements
- R1: After reset the block is in STOP with nothing armed, and `pass_en` and `clk_on` are low even while strobes arrive.
- R2: `pass_en` is high only in a cycle where `pulse_stb` is high.
- R3: A rising edge of `key_norm` selects NORMAL from the next cycle. In NORMAL every strobe passes and `clk_on` stays high.
- R4: In REPEAT, `rate_tick` high in a cycle arms one pulse from the next cycle. The next strobe passes it and disarms. Several ticks before a strobe still allow only one pulse.
- R5: A `key_step` edge outside STOP enters STOP with nothing armed, so no pulse passes. A `key_step` edge inside STOP arms exactly one pulse, however many presses occur before the next strobe.
- R6: A `key_digit` edge enters DIGIT and arms delivery. Strobes pass until one passes while the registered digit-end flag is high. That flag holds the value of `digit_end_n` (inverted) from the previous cycle. Delivery then stops.
- R7: A `key_num` edge enters NUMBER and behaves like R6, using the registered number-end flag taken from `number_end_n`.
- R8: Outside NORMAL, a falling edge of `host_key_n` opens delivery two cycles later. With `HOST_COUNT_STOP` = 0, delivery closes once `op_start_n` is low in a cycle: from two cycles later, no host-opened strobe passes. This close wins over a coinciding open.
- R9: With `HOST_COUNT_STOP` = 1, host-opened delivery passes exactly `HOST_PULSES` strobes and then closes, and `op_start_n` has no effect.
- R10: Mode key edges in the same cycle resolve with the priority `key_num` > `key_digit` > `key_step` > `key_rpt` > `key_norm`.
- R11: A mode key held high acts only on its rising edge.
- R12: `clk_on` is high exactly when a strobe arriving in that cycle would pass.
- R13: A boundary marker presented in a cycle that is followed by a cycle without a strobe has no effect, and DIGIT or NUMBER delivery continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_stb | input | 1 | One-cycle strobe per master pulse |
| key_norm | input | 1 | NORMAL mode key, active high |
| key_rpt | input | 1 | REPEAT mode key, active high |
| key_step | input | 1 | STOP/step key, active high |
| key_digit | input | 1 | DIGIT step key, active high |
| key_num | input | 1 | NUMBER step key, active high |
| rate_tick | input | 1 | Repeat-rate tick, one cycle |
| host_key_n | input | 1 | Host keypress flag, active low |
| op_start_n | input | 1 | Host operation-started flag, active low |
| digit_end_n | input | 1 | Digit-cycle end marker, active low |
| number_end_n | input | 1 | Number-cycle end marker, active low |
| pass_en | output | 1 | Forward this cycle's master pulse |
| clk_on | output | 1 | Delivery currently enabled |

## Verification
The hardest situation to reach is a host-opened run that overlaps a held operation-started flag. The counted and flag-stopped variants must then diverge by exactly two pulses. The bench runs both variants side by side from the same stimulus. It holds the host flag low and asserts the operation flag part-way through a dense strobe burst, so that both close conditions fall inside one burst. A marker placed just before a strobe-free cycle checks that registered sampling ignores the marker.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

    localparam int NUM_KEYS  = 5;
    // key index doubles as priority: larger index wins
    localparam int KEY_NORM  = 0;
    localparam int KEY_RPT   = 1;
    localparam int KEY_STEP  = 2;
    localparam int KEY_DIGIT = 3;
    localparam int KEY_NUM   = 4;

    typedef enum logic [2:0] {
        GM_NORMAL,
        GM_REPEAT,
        GM_STOP,
        GM_DIGIT,
        GM_NUMBER
    } gate_mode_e;

endpackage

// File: rtl/pgc_inbound.sv
module pgc_inbound #(
    parameter int NKEYS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NKEYS-1:0] keys,
    input  logic             host_key_n,
    input  logic             op_start_n,
    input  logic             digit_end_n,
    input  logic             number_end_n,
    output logic [NKEYS-1:0] key_edge,
    output logic             host_rise,
    output logic             op_flag,
    output logic             digit_flag,
    output logic             number_flag
);

    logic [NKEYS-1:0] key_q;
    logic             host_q;
    logic             host_qq;

    genvar g;
    generate
        for (g = 0; g < NKEYS; g++) begin : g_key
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) key_q[g] <= 1'b0;
                else        key_q[g] <= keys[g];
            end
            assign key_edge[g] = keys[g] & ~key_q[g];
        end
    endgenerate

    // host flags: invert at the boundary, register once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_q      <= 1'b0;
            host_qq     <= 1'b0;
            op_flag     <= 1'b0;
            digit_flag  <= 1'b0;
            number_flag <= 1'b0;
        end else begin
            host_q      <= ~host_key_n;
            host_qq     <= host_q;
            op_flag     <= ~op_start_n;
            digit_flag  <= ~digit_end_n;
            number_flag <= ~number_end_n;
        end
    end

    assign host_rise = host_q & ~host_qq;

endmodule

// File: rtl/pgc_keysel.sv
module pgc_keysel #(
    parameter int NKEYS = 5
) (
    input  logic [NKEYS-1:0] key_edge,
    output logic [NKEYS-1:0] win,
    output logic             any
);

    always_comb begin
        win = '0;
        for (int i = 0; i < NKEYS; i++) begin
            if (key_edge[i]) begin
                win    = '0;
                win[i] = 1'b1;
            end
        end
    end

    assign any = |key_edge;

endmodule

// File: rtl/pgc_host.sv
module pgc_host #(
    parameter bit HOST_COUNT_STOP = 1'b0,
    parameter int HOST_PULSES     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_normal,
    input  logic host_rise,
    input  logic op_flag,
    input  logic pass_en,
    output logic host_run
);

    localparam int CNT_W = (HOST_PULSES > 2) ? $clog2(HOST_PULSES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOST_PULSES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             op_close;
    logic             cnt_close;

    assign op_close  = !HOST_COUNT_STOP && op_flag;
    assign cnt_close = HOST_COUNT_STOP && host_run && pass_en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_run <= 1'b0;
            cnt_q    <= '0;
        end else if (in_normal) begin
            host_run <= 1'b0;
            cnt_q    <= '0;
        end else if (op_close) begin
            host_run <= 1'b0;
        end else if (host_rise) begin
            host_run <= 1'b1;
            cnt_q    <= '0;
        end else if (cnt_close) begin
            host_run <= 1'b0;
            cnt_q    <= '0;
        end else if (HOST_COUNT_STOP && host_run && pass_en) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pulse_gate_ctrl.sv
module pulse_gate_ctrl #(
    parameter bit HOST_COUNT_STOP = 1'b0,
    parameter int HOST_PULSES     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_stb,
    input  logic key_norm,
    input  logic key_rpt,
    input  logic key_step,
    input  logic key_digit,
    input  logic key_num,
    input  logic rate_tick,
    input  logic host_key_n,
    input  logic op_start_n,
    input  logic digit_end_n,
    input  logic number_end_n,
    output logic pass_en,
    output logic clk_on
);
    import pgc_pkg::*;

    logic [NUM_KEYS-1:0] keys_v;
    logic [NUM_KEYS-1:0] key_edge;
    logic [NUM_KEYS-1:0] win;
    logic                any_key;
    logic                host_rise;
    logic                op_flag;
    logic                digit_flag;
    logic                number_flag;
    logic                host_run;

    gate_mode_e mode_q, mode_d;
    logic       armed_q, armed_d;

    assign keys_v[KEY_NORM]  = key_norm;
    assign keys_v[KEY_RPT]   = key_rpt;
    assign keys_v[KEY_STEP]  = key_step;
    assign keys_v[KEY_DIGIT] = key_digit;
    assign keys_v[KEY_NUM]   = key_num;

    pgc_inbound #(.NKEYS(NUM_KEYS)) u_in (
        .clk(clk), .rst_n(rst_n), .keys(keys_v),
        .host_key_n(host_key_n), .op_start_n(op_start_n),
        .digit_end_n(digit_end_n), .number_end_n(number_end_n),
        .key_edge(key_edge), .host_rise(host_rise), .op_flag(op_flag),
        .digit_flag(digit_flag), .number_flag(number_flag)
    );

    pgc_keysel #(.NKEYS(NUM_KEYS)) u_sel (
        .key_edge(key_edge), .win(win), .any(any_key)
    );

    pgc_host #(.HOST_COUNT_STOP(HOST_COUNT_STOP), .HOST_PULSES(HOST_PULSES)) u_host (
        .clk(clk), .rst_n(rst_n), .in_normal(mode_q == GM_NORMAL),
        .host_rise(host_rise), .op_flag(op_flag), .pass_en(pass_en),
        .host_run(host_run)
    );

    // next-state
    always_comb begin
        mode_d  = mode_q;
        armed_d = armed_q;
        if (any_key) begin
            if (win[KEY_NUM]) begin
                mode_d  = GM_NUMBER;
                armed_d = 1'b1;
            end else if (win[KEY_DIGIT]) begin
                mode_d  = GM_DIGIT;
                armed_d = 1'b1;
            end else if (win[KEY_STEP]) begin
                armed_d = (mode_q == GM_STOP);
                mode_d  = GM_STOP;
            end else if (win[KEY_RPT]) begin
                mode_d  = GM_REPEAT;
                armed_d = 1'b0;
            end else begin
                mode_d  = GM_NORMAL;
                armed_d = 1'b0;
            end
        end else begin
            unique case (mode_q)
                GM_NORMAL: armed_d = 1'b0;
                GM_REPEAT: begin
                    if (rate_tick)    armed_d = 1'b1;
                    else if (pass_en) armed_d = 1'b0;
                end
                GM_STOP:   if (pass_en) armed_d = 1'b0;
                GM_DIGIT:  if (pass_en && digit_flag) armed_d = 1'b0;
                GM_NUMBER: if (pass_en && number_flag) armed_d = 1'b0;
                default:   armed_d = 1'b0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= GM_STOP;
            armed_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            armed_q <= armed_d;
        end
    end

    // outputs
    always_comb begin
        clk_on  = (mode_q == GM_NORMAL) || armed_q || host_run;
        pass_en = pulse_stb && clk_on;
    end

endmodule

// File: rtl/pgc_sva.sv
module pgc_sva #(
    parameter bit HOST_COUNT_STOP = 1'b0
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           pulse_stb,
    input logic                           pass_en,
    input logic                           clk_on,
    input pgc_pkg::gate_mode_e            mode_q,
    input logic                           armed_q,
    input logic                           host_run,
    input logic                           host_rise,
    input logic                           op_flag,
    input logic                           digit_flag,
    input logic [pgc_pkg::NUM_KEYS-1:0]   key_edge,
    input logic [pgc_pkg::NUM_KEYS-1:0]   win
);
    import pgc_pkg::*;

    AST_NO_STRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_stb |-> !pass_en); // R2

    AST_PASS_MEANS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        pass_en |-> clk_on); // R12

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win)); // R10

    AST_NUMBER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        key_edge[KEY_NUM] |-> win[KEY_NUM]); // R10

    AST_NORMAL_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        win[KEY_NORM] |=> clk_on); // R3

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == GM_STOP && pass_en && !host_run && !host_rise && key_edge == '0)
        |=> !armed_q); // R5

    AST_DIGIT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == GM_DIGIT && pass_en && digit_flag && !host_run && !host_rise
         && key_edge == '0) |=> !clk_on); // R6

    AST_HOST_OP_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!HOST_COUNT_STOP && op_flag && mode_q != GM_NORMAL) |=> !host_run); // R8

endmodule

bind pulse_gate_ctrl pgc_sva #(.HOST_COUNT_STOP(HOST_COUNT_STOP)) u_sva (
    .clk(clk), .rst_n(rst_n), .pulse_stb(pulse_stb), .pass_en(pass_en),
    .clk_on(clk_on), .mode_q(mode_q), .armed_q(armed_q), .host_run(host_run),
    .host_rise(host_rise), .op_flag(op_flag), .digit_flag(digit_flag),
    .key_edge(key_edge), .win(win)
);

// File: tb/pgc_ref.sv
module pgc_ref #(
    parameter bit COUNT_STOP = 1'b0,
    parameter int NPULSE     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb,
    input  logic [4:0] keys,   // 0 norm,1 rpt,2 step,3 digit,4 number
    input  logic       tick,
    input  logic       host_n,
    input  logic       op_n,
    input  logic       de_n,
    input  logic       ne_n,
    output logic       exp_pass,
    output logic       exp_on
);
    // modes: 0 normal, 1 repeat, 2 stop, 3 digit, 4 number
    int   mode  = 2;
    bit   armed = 0;
    bit   host  = 0;
    int   cnt   = 0;
    bit   hk1 = 0, hk2 = 0, opd = 0, ded = 0, ned = 0;
    logic [4:0] prevk = '0;

    assign exp_on   = (mode == 0) || armed || host;
    assign exp_pass = stb && exp_on;

    always @(posedge clk) begin
        if (!rst_n) begin
            mode = 2; armed = 0; host = 0; cnt = 0;
            hk1 = 0; hk2 = 0; opd = 0; ded = 0; ned = 0; prevk = '0;
        end else begin
            automatic logic [4:0] edges = keys & ~prevk;
            automatic int  sel = -1;
            automatic bit  p = stb && ((mode == 0) || armed || host);
            automatic bit  rise = hk1 && !hk2;
            automatic int  old_mode = mode;
            for (int k = 0; k < 5; k++) if (edges[k]) sel = k;
            if (sel == 4) begin mode = 4; armed = 1; end
            else if (sel == 3) begin mode = 3; armed = 1; end
            else if (sel == 2) begin armed = (mode == 2); mode = 2; end
            else if (sel == 1) begin mode = 1; armed = 0; end
            else if (sel == 0) begin mode = 0; armed = 0; end
            else begin
                if (mode == 1) begin
                    if (tick) armed = 1; else if (p) armed = 0;
                end else if (mode == 2) begin
                    if (p) armed = 0;
                end else if (mode == 3) begin
                    if (p && ded) armed = 0;
                end else if (mode == 4) begin
                    if (p && ned) armed = 0;
                end
            end
            if (old_mode == 0) begin host = 0; cnt = 0; end
            else if (!COUNT_STOP && opd) host = 0;
            else if (rise) begin host = 1; cnt = 0; end
            else if (COUNT_STOP && host && p) begin
                if (cnt == NPULSE - 1) begin host = 0; cnt = 0; end
                else cnt++;
            end
            hk2 = hk1; hk1 = !host_n; opd = !op_n; ded = !de_n; ned = !ne_n;
            prevk = keys;
        end
    end
endmodule

// File: tb/tb_pulse_gate_ctrl.sv
module tb_pulse_gate_ctrl;
    logic clk = 0;
    logic rst_n = 0;
    logic stb = 0, tick = 0;
    logic [4:0] keys = '0;
    logic host_n = 1, op_n = 1, de_n = 1, ne_n = 1;
    logic pass_a, on_a, pass_b, on_b;
    logic exp_pass_a, exp_on_a, exp_pass_b, exp_on_b;

    int total = 0, failed = 0;
    int pc = 0, pcc = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;   // 250 MHz

    pulse_gate_ctrl #(.HOST_COUNT_STOP(1'b0), .HOST_PULSES(8)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_stb(stb),
        .key_norm(keys[0]), .key_rpt(keys[1]), .key_step(keys[2]),
        .key_digit(keys[3]), .key_num(keys[4]), .rate_tick(tick),
        .host_key_n(host_n), .op_start_n(op_n), .digit_end_n(de_n),
        .number_end_n(ne_n), .pass_en(pass_a), .clk_on(on_a));

    pulse_gate_ctrl #(.HOST_COUNT_STOP(1'b1), .HOST_PULSES(8)) dut_cnt (
        .clk(clk), .rst_n(rst_n), .pulse_stb(stb),
        .key_norm(keys[0]), .key_rpt(keys[1]), .key_step(keys[2]),
        .key_digit(keys[3]), .key_num(keys[4]), .rate_tick(tick),
        .host_key_n(host_n), .op_start_n(op_n), .digit_end_n(de_n),
        .number_end_n(ne_n), .pass_en(pass_b), .clk_on(on_b));

    pgc_ref #(.COUNT_STOP(1'b0), .NPULSE(8)) ref_a (
        .clk(clk), .rst_n(rst_n), .stb(stb), .keys(keys), .tick(tick),
        .host_n(host_n), .op_n(op_n), .de_n(de_n), .ne_n(ne_n),
        .exp_pass(exp_pass_a), .exp_on(exp_on_a));

    pgc_ref #(.COUNT_STOP(1'b1), .NPULSE(8)) ref_b (
        .clk(clk), .rst_n(rst_n), .stb(stb), .keys(keys), .tick(tick),
        .host_n(host_n), .op_n(op_n), .de_n(de_n), .ne_n(ne_n),
        .exp_pass(exp_pass_b), .exp_on(exp_on_b));

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference models
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            check(cur_req, "flag-variant pass/on", {pass_a, on_a}, {exp_pass_a, exp_on_a});
            check(cur_req, "count-variant pass/on", {pass_b, on_b}, {exp_pass_b, exp_on_b});
            if (pass_a) pc++;
            if (pass_b) pcc++;
        end
    end

    task automatic idle();
        @(negedge clk);
        stb = 0; keys = '0; tick = 0; de_n = 1; ne_n = 1;
    endtask

    task automatic press(input logic [4:0] k);
        @(negedge clk);
        stb = 0; tick = 0; keys = k;
        @(negedge clk);
        keys = '0;
    endtask

    // which: 0 none, 1 digit marker, 2 number marker
    task automatic run(input int n, input int per, input int mark_at, input int which);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            stb  = (i % per == 0);
            keys = '0; tick = 0;
            de_n = !(which == 1 && i == mark_at);
            ne_n = !(which == 2 && i == mark_at);
        end
        idle();
    endtask

    task automatic start(input string req);
        cur_req = req;
        pc = 0; pcc = 0;
    endtask

    task automatic check_on(input string req, input int exp);
        #1;
        check(req, "clk_on", on_a, exp);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - failed, total);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, strobes ignored
        start("R1");
        #1;
        check("R1", "clk_on after reset", on_a, 0);
        run(10, 1, 0, 0);
        check("R1", "passes after reset", pc, 0);

        // R5: step inside STOP
        start("R5");
        for (int j = 0; j < 3; j++) begin
            press(5'b00100);
            run(4, 2, 0, 0);
        end
        check("R5", "one pulse per step press", pc, 3);
        start("R5");
        press(5'b00100);
        press(5'b00100);
        run(6, 1, 0, 0);
        check("R5", "double press before strobe", pc, 1);

        // R3: normal
        start("R3");
        press(5'b00001);
        run(10, 2, 0, 0);
        check("R3", "normal passes all strobes", pc, 5);
        check_on("R3", 1);

        // R5: step leaves normal
        start("R5");
        press(5'b00100);
        run(6, 1, 0, 0);
        check("R5", "step from normal passes none", pc, 0);
        check_on("R5", 0);

        // R4: repeat
        start("R4");
        press(5'b00010);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk); stb = 0; tick = 1;
            run(3, 1, 0, 0);
        end
        check("R4", "one pulse per tick", pc, 4);
        start("R4");
        @(negedge clk); stb = 0; tick = 1;
        @(negedge clk); stb = 0; tick = 1;
        run(3, 1, 0, 0);
        check("R4", "ticks do not accumulate", pc, 1);

        // R6: digit step
        start("R6");
        press(5'b01000);
        run(8, 1, 2, 1);
        check("R6", "digit run of four", pc, 4);
        check_on("R6", 0);

        // R13: marker before a strobe-free cycle ignored
        start("R13");
        press(5'b01000);
        run(10, 2, 2, 1);
        check("R13", "marker without strobe ignored", pc, 5);
        check_on("R13", 1);

        // R7: number step
        start("R7");
        press(5'b10000);
        run(20, 1, 9, 2);
        check("R7", "number run length", pc, 11);
        check_on("R7", 0);

        // R8 / R9: host keypress, both variants
        start("R8");
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            stb = 1; host_n = 0; op_n = !(i >= 6);
        end
        idle();
        host_n = 1; op_n = 1;
        idle();
        idle();
        check("R8", "host run closed by op flag", pc, 6);
        check("R9", "host run closed after eight", pcc, 8);

        // R10: priority
        start("R10");
        press(5'b11111);
        run(6, 1, 0, 0);
        check("R10", "number beats all", pc, 6);
        start("R10");
        press(5'b00111);
        run(4, 1, 0, 0);
        check("R10", "step beats repeat and normal", pc, 0);
        start("R10");
        press(5'b00011);
        run(4, 1, 0, 0);
        check("R10", "repeat beats normal", pc, 0);

        // R11: held key acts once
        start("R11");
        press(5'b00100);
        @(negedge clk); stb = 0; keys = 5'b00100;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); stb = 1; keys = 5'b00100;
        end
        idle();
        check("R11", "held step gives one pulse", pc, 1);
        check_on("R12", 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; failed++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end
endmodule